// File: doc/BRIEF.md
# Polled and Interrupt-Driven Character Port

This block lets a processor exchange characters with one keyboard-like source and one display-like sink through four byte-wide registers placed in the ordinary memory address space. The processor finds the registers by address: the upper address bits must match a base value, and the two low bits pick the register. Software can poll the status register for readiness, or it can turn on per-direction interrupt enables in the control register and let the block raise an interrupt request.

There is no explicit acknowledge. Reading the received-character register clears input-ready and drops the keyboard request. Writing the transmit-character register clears output-ready and drops the display request until the sink accepts the byte. The keyboard side is a valid/ready stream whose ready is always high, so a character arriving before the last one was read replaces it and is flagged as an overrun. The display side is a valid/ready stream: the block holds valid and the byte steady until ready is seen high at a clock edge.

Register offsets (low two address bits): 0 status, 1 control, 2 received character, 3 transmit character. Status: bit 0 input-ready, bit 1 output-ready, bit 3 overrun. Control: bit 2 keyboard interrupt enable, bit 3 display interrupt enable.

Top module: `cdev_port`

## Requirements
- R1: After reset, status reads 0x02 (output-ready only), control reads 0x00, `dp_valid` and all interrupt outputs are low, and `kb_ready` is high.
- R2: Only addresses whose upper bits equal the base respond. A read of any other address returns 0x00, and a write to it changes no register.
- R3: A clock edge with `kb_valid` high captures `kb_data` into the received-character register and sets status bit 0. `kb_ready` stays high at all times.
- R4: A read of offset 2 returns the stored character. After that edge, status bit 0 is clear unless a new character arrived at the same edge.
- R5: A character that arrives while status bit 0 is set, with no read of offset 2 at that edge, overwrites the stored character and sets status bit 3. A read of offset 0 returns bit 3 set and clears it at that edge.
- R6: When a read of offset 2 and an arriving character share one edge, the read returns the old character. The new character is then stored, status bit 0 stays set and no overrun is flagged.
- R7: `irq_kb` is high exactly while status bit 0 and control bit 2 are both set. `irq` is the OR of `irq_kb` and `irq_dp`.
- R8: A write to offset 3 while status bit 1 is set raises `dp_valid` with the written byte on `dp_data` after that edge and clears status bit 1. Valid and data stay steady while `dp_ready` is low.
- R9: After an edge with `dp_valid` and `dp_ready` both high, `dp_valid` is low and status bit 1 is set again.
- R10: A write to offset 3 while status bit 1 is clear is ignored. Both `dp_data` and the value read back from offset 3, which is the last accepted byte, remain unchanged.
- R11: `irq_dp` is high exactly while status bit 1 and control bit 3 are both set.
- R12: Writes to offset 0 are ignored. Control keeps only bits 2 and 3. Every unused bit of every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Processor address |
| bus_rd | input | 1 | Read strobe; read side effects occur at the edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational while `bus_rd` is high |
| kb_valid | input | 1 | Keyboard character valid |
| kb_data | input | DW | Keyboard character |
| kb_ready | output | 1 | Keyboard ready, always high |
| dp_valid | output | 1 | Display byte valid |
| dp_data | output | DW | Display byte |
| dp_ready | input | 1 | Display accepts the byte |
| irq_kb | output | 1 | Keyboard interrupt request |
| irq_dp | output | 1 | Display interrupt request |
| irq | output | 1 | Combined interrupt request |

## Verification
Read data is combinational, so the bench samples it a quarter period after it drives the strobe, before the edge that applies the read's side effect. Effects of an edge, such as status bits, `dp_valid` and the interrupt lines, are due one edge after the stimulus. The bench drives inputs on the falling edge and checks at the following falling edge, which is exactly one rising edge later. The shared-edge case and the held-busy case are checked with the stimuli kept in place across the edges concerned, so each result is observed in the cycle it is due.

// File: rtl/cdev_pkg.sv
package cdev_pkg;
  localparam int NREG       = 4;
  localparam int OFF_STAT   = 0;
  localparam int OFF_CTRL   = 1;
  localparam int OFF_DIN    = 2;
  localparam int OFF_DOUT   = 3;
  localparam int ST_IN_RDY  = 0;
  localparam int ST_OUT_RDY = 1;
  localparam int ST_OVR     = 3;
  localparam int CT_KB_IE   = 2;
  localparam int CT_DP_IE   = 3;
endpackage

// File: rtl/cdev_decode.sv
module cdev_decode #(
  parameter int ADDR_W = 16,
  parameter int NREG = 4,
  parameter logic [ADDR_W-1:0] BASE = 16'hFF00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel
);
  localparam int OFFS_W = $clog2(NREG);

  logic hit;
  assign hit = (addr[ADDR_W-1:OFFS_W] == BASE[ADDR_W-1:OFFS_W]);

  // one select line per register in the window
  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign sel[g] = hit && (addr[OFFS_W-1:0] == OFFS_W'(g));
  end
endmodule

// File: rtl/cdev_rx.sv
module cdev_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kb_valid,
  input  logic [DW-1:0] kb_data,
  output logic          kb_ready,
  input  logic          rd_din,
  input  logic          rd_stat,
  output logic [DW-1:0] din_q,
  output logic          in_rdy,
  output logic          ovr
);
  assign kb_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q  <= '0;
      in_rdy <= 1'b0;
    end else if (kb_valid) begin
      din_q  <= kb_data;
      in_rdy <= 1'b1;
    end else if (rd_din) begin
      in_rdy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr <= 1'b0;
    end else if (kb_valid && in_rdy && !rd_din) begin
      ovr <= 1'b1;
    end else if (rd_stat) begin
      ovr <= 1'b0;
    end
  end

  // R3
  arrival_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> in_rdy && (din_q == $past(kb_data)));
  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_din && !kb_valid |=> !in_rdy);
  // R5
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid && in_rdy && !rd_din |=> ovr);
endmodule

// File: rtl/cdev_tx.sv
module cdev_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_dout,
  input  logic [DW-1:0] wdata,
  output logic          dp_valid,
  output logic [DW-1:0] dp_data,
  input  logic          dp_ready,
  output logic          out_rdy
);
  assign out_rdy = !dp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_data  <= '0;
    end else if (dp_valid) begin
      if (dp_ready) dp_valid <= 1'b0;
    end else if (wr_dout) begin
      dp_valid <= 1'b1;
      dp_data  <= wdata;
    end
  end

  // R8
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid && !dp_ready |=> dp_valid && $stable(dp_data));
  // R9
  release_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid && dp_ready |=> !dp_valid);
  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout && dp_valid |=> $stable(dp_data));
endmodule

// File: rtl/cdev_port.sv
module cdev_port
  import cdev_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DW = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              kb_valid,
  input  logic [DW-1:0]     kb_data,
  output logic              kb_ready,
  output logic              dp_valid,
  output logic [DW-1:0]     dp_data,
  input  logic              dp_ready,
  output logic              irq_kb,
  output logic              irq_dp,
  output logic              irq
);
  logic [NREG-1:0] sel;
  logic [DW-1:0]   din_q;
  logic            in_rdy, ovr, out_rdy;
  logic            kb_ie, dp_ie;
  logic            rd_stat, rd_din, wr_ctrl, wr_dout;
  logic [DW-1:0]   stat_v, ctrl_v;

  cdev_decode #(.ADDR_W(ADDR_W), .NREG(NREG), .BASE(BASE)) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  assign rd_stat = bus_rd && sel[OFF_STAT];
  assign rd_din  = bus_rd && sel[OFF_DIN];
  assign wr_ctrl = bus_wr && sel[OFF_CTRL];
  assign wr_dout = bus_wr && sel[OFF_DOUT];

  cdev_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .kb_data(kb_data),
    .kb_ready(kb_ready), .rd_din(rd_din), .rd_stat(rd_stat),
    .din_q(din_q), .in_rdy(in_rdy), .ovr(ovr)
  );

  cdev_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_dout(wr_dout), .wdata(bus_wdata),
    .dp_valid(dp_valid), .dp_data(dp_data), .dp_ready(dp_ready),
    .out_rdy(out_rdy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kb_ie <= 1'b0;
      dp_ie <= 1'b0;
    end else if (wr_ctrl) begin
      kb_ie <= bus_wdata[CT_KB_IE];
      dp_ie <= bus_wdata[CT_DP_IE];
    end
  end

  always_comb begin
    stat_v = '0;
    stat_v[ST_IN_RDY]  = in_rdy;
    stat_v[ST_OUT_RDY] = out_rdy;
    stat_v[ST_OVR]     = ovr;
    ctrl_v = '0;
    ctrl_v[CT_KB_IE] = kb_ie;
    ctrl_v[CT_DP_IE] = dp_ie;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel[OFF_STAT]) bus_rdata = bus_rdata | stat_v;
      if (sel[OFF_CTRL]) bus_rdata = bus_rdata | ctrl_v;
      if (sel[OFF_DIN])  bus_rdata = bus_rdata | din_q;
      if (sel[OFF_DOUT]) bus_rdata = bus_rdata | dp_data;
    end
  end

  assign irq_kb = in_rdy && kb_ie;
  assign irq_dp = out_rdy && dp_ie;
  assign irq    = irq_kb || irq_dp;

  // R7
  kb_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_din && !kb_valid |=> !irq_kb);
  // R11
  dp_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout && out_rdy |=> !irq_dp);
endmodule

// File: tb/test_cdev_port.sv
module test_cdev_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'hFF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        kb_valid = 1'b0;
  logic [7:0]  kb_data = '0;
  logic        kb_ready, dp_valid, dp_ready = 1'b0;
  logic [7:0]  dp_data;
  logic        irq_kb, irq_dp, irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdev_port #(.ADDR_W(16), .DW(8), .BASE(BASE)) i_cdev_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_data(kb_data), .kb_ready(kb_ready),
    .dp_valid(dp_valid), .dp_data(dp_data), .dp_ready(dp_ready),
    .irq_kb(irq_kb), .irq_dp(irq_dp), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #(CLK_PERIOD/4);
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic kb_push(input logic [7:0] c);
    @(negedge clk);
    kb_valid = 1'b1; kb_data = c;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 dp_valid", {7'b0, dp_valid}, 8'h00);
    check("R1 irq", {5'b0, irq, irq_kb, irq_dp}, 8'h00);
    check("R1 kb_ready", {7'b0, kb_ready}, 8'h01);
    bus_read(BASE + 16'd0, v); check("R1 status", v, 8'h02);
    bus_read(BASE + 16'd1, v); check("R1 control", v, 8'h00);
  endtask

  task automatic t_decode;
    logic [7:0] v;
    bus_write(BASE + 16'd5, 8'hFF);
    bus_read(BASE + 16'd1, v); check("R2 stray write", v, 8'h00);
    bus_read(BASE - 16'd1, v); check("R2 stray read", v, 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    bus_write(BASE + 16'd1, 8'hFF);
    bus_read(BASE + 16'd1, v); check("R12 control bits", v, 8'h0C);
    check("R11 irq_dp idle", {6'b0, irq_dp, irq}, 8'h03);
    bus_write(BASE + 16'd0, 8'hFF);
    bus_read(BASE + 16'd0, v); check("R12 status write", v, 8'h02);
    bus_write(BASE + 16'd1, 8'h00);
    check("R11 irq_dp off", {6'b0, irq_dp, irq}, 8'h00);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    kb_push(8'h41);
    check("R3 kb_ready", {7'b0, kb_ready}, 8'h01);
    check("R7 no irq when disabled", {6'b0, irq_kb, irq}, 8'h00);
    bus_read(BASE + 16'd0, v); check("R3 status", v, 8'h03);
    bus_write(BASE + 16'd1, 8'h04);
    check("R7 irq_kb on", {6'b0, irq_kb, irq}, 8'h03);
    bus_read(BASE + 16'd2, v); check("R4 data", v, 8'h41);
    check("R4 irq_kb dropped", {6'b0, irq_kb, irq}, 8'h00);
    bus_read(BASE + 16'd0, v); check("R4 status", v, 8'h02);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    kb_push(8'h31);
    kb_push(8'h32);
    bus_read(BASE + 16'd0, v); check("R5 overrun set", v, 8'h0B);
    bus_read(BASE + 16'd0, v); check("R5 overrun cleared", v, 8'h03);
    bus_read(BASE + 16'd2, v); check("R5 overwrite", v, 8'h32);
  endtask

  task automatic t_same_edge;
    logic [7:0] v;
    kb_push(8'h50);
    @(negedge clk);
    bus_addr = BASE + 16'd2; bus_rd = 1'b1; kb_valid = 1'b1; kb_data = 8'h51;
    #(CLK_PERIOD/4);
    check("R6 old data", bus_rdata, 8'h50);
    @(negedge clk);
    bus_rd = 1'b0; kb_valid = 1'b0;
    check("R6 irq_kb kept", {7'b0, irq_kb}, 8'h01);
    bus_read(BASE + 16'd0, v); check("R6 status", v, 8'h03);
    bus_read(BASE + 16'd2, v); check("R6 new data", v, 8'h51);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    dp_ready = 1'b0;
    bus_write(BASE + 16'd1, 8'h08);
    check("R11 irq_dp ready", {7'b0, irq_dp}, 8'h01);
    bus_write(BASE + 16'd3, 8'h5A);
    check("R8 dp_valid", {7'b0, dp_valid}, 8'h01);
    check("R8 dp_data", dp_data, 8'h5A);
    check("R11 irq_dp busy", {7'b0, irq_dp}, 8'h00);
    bus_read(BASE + 16'd0, v); check("R8 status", v, 8'h00);
    bus_write(BASE + 16'd3, 8'h77);
    check("R10 dp_data", dp_data, 8'h5A);
    bus_read(BASE + 16'd3, v); check("R10 readback", v, 8'h5A);
    repeat (3) @(negedge clk);
    check("R8 held", {7'b0, dp_valid}, 8'h01);
    dp_ready = 1'b1;
    @(negedge clk);
    dp_ready = 1'b0;
    check("R9 dp_valid low", {7'b0, dp_valid}, 8'h00);
    check("R11 irq_dp back", {6'b0, irq_dp, irq}, 8'h03);
    bus_read(BASE + 16'd0, v); check("R9 status", v, 8'h02);
    bus_read(BASE + 16'd3, v); check("R10 no late write", v, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_ctrl();
    t_rx();
    t_overrun();
    t_same_edge();
    t_tx();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule